// File: doc/BRIEF.md
# Display Enable and Sync Generator

This block turns the counter values of a character-based video timing chain into the three outputs a display pipeline needs: a horizontal sync pulse, a vertical sync pulse and a composite display-enable. Display-enable is low while any border is active. The timing chain supplies the character position within a line, the raster line within a character row and the character-row number. The block compares these against programmed limits for the displayed area, the sync positions and the sync widths. It does not own the counters.

Horizontal and vertical borders are set/clear flip-flops. An external split-border input can blank the display as well. The combined enable can be delayed by zero, one or two character periods, or held off. Each sync pulse has its own 4-bit width counter. The horizontal counter advances once per character and the vertical counter advances once per raster line. All outputs are registered.

Top module: `vsg_sync_gen`

## Requirements
- R1: The horizontal border becomes active after a cycle where `hcc` equals `r_hdisp`. It becomes inactive after a cycle where `hcc` is 0. When both conditions hold in the same cycle, the border is active.
- R2: The vertical border becomes active after a cycle where `vcc` equals `r_vdisp`. It becomes inactive after a cycle where `vcc` is 0. When both hold together, the border is active.
- R3: The undelayed enable is the NOR of the horizontal border, the vertical border and `split_border`. With no skew, `disp_en` shows it one cycle later.
- R4: `hsync` rises the cycle after `hcc` equals `r_hsync_pos`. A match while `hsync` is high is ignored.
- R5: The horizontal width is `r_sync_width[3:0]`, counted in characters. A width of 0 gives no pulse. A pulse that ends in the same cycle as a position match is not restarted, so two pulses are never adjacent.
- R6: `vsync` rises the cycle after a cycle with `vcc` equal to `r_vsync_pos`, `hcc` = 0 and `vlc` = 0, provided no vertical pulse is in progress. A match during a pulse is ignored.
- R7: The vertical width is `r_sync_width[7:4]` raster lines, counted at each `hcc` = 0. A value of 0 gives 16 lines.
- R8: `r_skew` delays the enable. 00 gives no extra delay, 01 gives one cycle, 10 gives two cycles, and 11 holds `disp_en` low.
- R9: If a width is lowered below the running count during a pulse, the 4-bit counter runs on through 15, wraps to 0, and ends the pulse when the count next reaches the new width.
- R10: While `rst_n` is low, `hsync`, `vsync` and `disp_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcc | input | 8 | Character position within the line |
| vlc | input | 5 | Raster line within the character row |
| vcc | input | 7 | Character-row number |
| split_border | input | 1 | External border request |
| r_hdisp | input | 8 | Displayed characters per line |
| r_hsync_pos | input | 8 | Horizontal sync start position |
| r_sync_width | input | 8 | Vertical width [7:4], horizontal width [3:0] |
| r_vdisp | input | 7 | Displayed character rows |
| r_vsync_pos | input | 7 | Vertical sync start row |
| r_skew | input | 2 | Display-enable delay select |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable, low in the border |

## Verification
The properties assume that the counter inputs change only at clock edges, and that `hcc` returns to 0 once per raster line so that the vertical width counter has steps to count. The stimulus steps `hcc`, `vlc` and `vcc` through complete frames of small geometries. Register values change only between clock edges. The one exception is the mid-pulse width change, which is made on purpose to exercise the counter wrap. Other stimulus patterns cover border conflicts, an adjacent sync match and a vertical match during a pulse. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   typedef logic [1:0] skew_t;
   localparam skew_t SKEW_NONE = 2'b00;
   localparam skew_t SKEW_OFF  = 2'b11;
   localparam int    SYNC_CW   = 4;
endpackage

// File: rtl/vsg_border.sv
module vsg_border #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] count,
   input  logic [W-1:0] limit,
   output logic         border_nxt,
   output logic         border
);
   logic hit_set, hit_clr;
   assign hit_set = (count == limit);
   assign hit_clr = (count == '0);

   // set dominates clear when both fire
   always_comb begin
      if (hit_set)      border_nxt = 1'b1;
      else if (hit_clr) border_nxt = 1'b0;
      else              border_nxt = border;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) border <= 1'b1;
      else        border <= border_nxt;
   end
endmodule

// File: rtl/vsg_sync_ctr.sv
module vsg_sync_ctr #(
   parameter int CW             = 4,
   parameter bit ZERO_MEANS_MAX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_hit,
   input  logic          step,
   input  logic [CW-1:0] width,
   output logic          active
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic          width_ok;

   assign cnt_inc = cnt + 1'b1;

   generate
      if (ZERO_MEANS_MAX) begin : g_zero_full
         assign width_ok = 1'b1;
      end else begin : g_zero_none
         assign width_ok = (width != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (active) begin
         if (step) begin
            cnt <= cnt_inc;
            if (cnt_inc == width) active <= 1'b0;
         end
      end else if (start_hit && width_ok) begin
         active <= 1'b1;
         cnt    <= '0;
      end
   end
endmodule

// File: rtl/vsg_skew.sv
module vsg_skew #(
   parameter int MAX_SKEW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              de_in,
   input  vsg_pkg::skew_t    sel,
   output logic              de_out
);
   localparam int NSTG = (MAX_SKEW < 1) ? 1 : MAX_SKEW;

   logic [NSTG:0] stage;
   assign stage[0] = de_in;

   generate
      for (genvar i = 1; i <= NSTG; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= stage[i-1];
         end
      end
   endgenerate

   logic de_pick;
   always_comb begin
      de_pick = 1'b0;
      if (sel != vsg_pkg::SKEW_OFF && int'(sel) <= MAX_SKEW)
         de_pick = stage[sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) de_out <= 1'b0;
      else        de_out <= de_pick;
   end
endmodule

// File: rtl/vsg_sync_gen.sv
module vsg_sync_gen #(
   parameter int HCW      = 8,
   parameter int VLW      = 5,
   parameter int VCW      = 7,
   parameter int MAX_SKEW = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [HCW-1:0]             hcc,
   input  logic [VLW-1:0]             vlc,
   input  logic [VCW-1:0]             vcc,
   input  logic                       split_border,
   input  logic [HCW-1:0]             r_hdisp,
   input  logic [HCW-1:0]             r_hsync_pos,
   input  logic [2*vsg_pkg::SYNC_CW-1:0] r_sync_width,
   input  logic [VCW-1:0]             r_vdisp,
   input  logic [VCW-1:0]             r_vsync_pos,
   input  logic [1:0]                 r_skew,
   output logic                       hsync,
   output logic                       vsync,
   output logic                       disp_en
);
   localparam int SW = vsg_pkg::SYNC_CW;

   generate
      if (HCW < 4 || VCW < 2 || VLW < 1) begin : g_bad_width
         $error("vsg_sync_gen: counter widths too small");
      end
      if (MAX_SKEW < 1 || MAX_SKEW > 2) begin : g_bad_skew
         $error("vsg_sync_gen: MAX_SKEW must be 1 or 2");
      end
   endgenerate

   logic hb_nxt, hb_q, vb_nxt, vb_q;
   logic line_start, row_start;
   logic de_raw;

   assign line_start = (hcc == '0);
   assign row_start  = line_start && (vlc == '0);

   vsg_border #(.W(HCW)) u_hbrd (
      .clk(clk), .rst_n(rst_n), .count(hcc), .limit(r_hdisp),
      .border_nxt(hb_nxt), .border(hb_q));

   vsg_border #(.W(VCW)) u_vbrd (
      .clk(clk), .rst_n(rst_n), .count(vcc), .limit(r_vdisp),
      .border_nxt(vb_nxt), .border(vb_q));

   assign de_raw = ~(hb_nxt | vb_nxt | split_border);

   vsg_skew #(.MAX_SKEW(MAX_SKEW)) u_skew (
      .clk(clk), .rst_n(rst_n), .de_in(de_raw), .sel(r_skew),
      .de_out(disp_en));

   vsg_sync_ctr #(.CW(SW), .ZERO_MEANS_MAX(1'b0)) u_hctr (
      .clk(clk), .rst_n(rst_n),
      .start_hit(hcc == r_hsync_pos), .step(1'b1),
      .width(r_sync_width[SW-1:0]), .active(hsync));

   vsg_sync_ctr #(.CW(SW), .ZERO_MEANS_MAX(1'b1)) u_vctr (
      .clk(clk), .rst_n(rst_n),
      .start_hit(row_start && (vcc == r_vsync_pos)), .step(line_start),
      .width(r_sync_width[2*SW-1:SW]), .active(vsync));
endmodule

// File: rtl/vsg_sync_gen_chk.sv
module vsg_sync_gen_chk #(
   parameter int HCW = 8,
   parameter int VLW = 5,
   parameter int VCW = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic [HCW-1:0] hcc,
   input logic [VLW-1:0] vlc,
   input logic [VCW-1:0] vcc,
   input logic           split_border,
   input logic [HCW-1:0] r_hdisp,
   input logic [HCW-1:0] r_hsync_pos,
   input logic [7:0]     r_sync_width,
   input logic [1:0]     r_skew,
   input logic [VCW-1:0] r_vsync_pos,
   input logic           hsync,
   input logic           vsync,
   input logic           disp_en
);
   // R1
   hconflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_skew == 2'b00 && hcc == '0 && r_hdisp == '0) |=> !disp_en);
   // R3
   split_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_skew == 2'b00 && split_border) |=> !disp_en);
   // R4
   hstart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> $past(hcc == r_hsync_pos));
   // R5
   hzero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |-> $past(r_sync_width[3:0] != 4'd0));
   // R6
   vstart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync) |-> $past(hcc == '0 && vlc == '0 && vcc == r_vsync_pos));
   // R8
   skew_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_skew == 2'b11) |=> !disp_en);
   // R10
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!hsync && !vsync && !disp_en);
      end
   end
endmodule

bind vsg_sync_gen vsg_sync_gen_chk #(.HCW(HCW), .VLW(VLW), .VCW(VCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .hcc(hcc), .vlc(vlc), .vcc(vcc),
   .split_border(split_border), .r_hdisp(r_hdisp),
   .r_hsync_pos(r_hsync_pos), .r_sync_width(r_sync_width),
   .r_skew(r_skew), .r_vsync_pos(r_vsync_pos),
   .hsync(hsync), .vsync(vsync), .disp_en(disp_en));

// File: tb/vsg_sync_gen_bench.sv
`timescale 1ns/1ps
module vsg_sync_gen_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [7:0] hcc = '0;
   logic [4:0] vlc = '0;
   logic [6:0] vcc = '0;
   logic       split_border = 1'b0;
   logic [7:0] r_hdisp = 8'd10, r_hsync_pos = 8'd12, r_sync_width = 8'h23;
   logic [6:0] r_vdisp = 7'd6, r_vsync_pos = 7'd8;
   logic [1:0] r_skew = 2'b00;
   logic       hsync, vsync, disp_en;

   vsg_sync_gen u_vsg_sync_gen (
      .clk(clk), .rst_n(rst_n), .hcc(hcc), .vlc(vlc), .vcc(vcc),
      .split_border(split_border), .r_hdisp(r_hdisp),
      .r_hsync_pos(r_hsync_pos), .r_sync_width(r_sync_width),
      .r_vdisp(r_vdisp), .r_vsync_pos(r_vsync_pos), .r_skew(r_skew),
      .hsync(hsync), .vsync(vsync), .disp_en(disp_en));

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "R10";
   bit    done     = 1'b0;

   // behavioural reference
   bit m_hb, m_vb, m_hs, m_vs, m_de;
   int h_run, v_run;
   bit de_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hb = 1; m_vb = 1; m_hs = 0; m_vs = 0; m_de = 0;
         h_run = 0; v_run = 0;
         de_q = '{0, 0, 0};
      end else begin
         bit now;
         if (hcc == r_hdisp) m_hb = 1; else if (hcc == 0) m_hb = 0;
         if (vcc == r_vdisp) m_vb = 1; else if (vcc == 0) m_vb = 0;
         now = !(m_hb || m_vb || split_border);
         de_q.push_front(now);
         while (de_q.size() > 3) void'(de_q.pop_back());
         m_de = (r_skew == 2'b11) ? 1'b0 : de_q[r_skew];
         if (m_hs) begin
            h_run = (h_run + 1) % 16;
            if (h_run == int'(r_sync_width[3:0])) m_hs = 0;
         end else if (hcc == r_hsync_pos && r_sync_width[3:0] != 0) begin
            m_hs = 1; h_run = 0;
         end
         if (m_vs) begin
            if (hcc == 0) begin
               v_run = (v_run + 1) % 16;
               if (v_run == int'(r_sync_width[7:4])) m_vs = 0;
            end
         end else if (hcc == 0 && vlc == 0 && vcc == r_vsync_pos) begin
            m_vs = 1; v_run = 0;
         end
      end
   end

   task automatic compare();
      n_checks++;
      if (hsync !== m_hs || vsync !== m_vs || disp_en !== m_de) begin
         n_fail++;
         $display("FAIL %s t=%0t hs/vs/de actual=%b%b%b expected=%b%b%b",
                  tag, $time, hsync, vsync, disp_en, m_hs, m_vs, m_de);
      end
   endtask

   // one frame walk; mid_lower changes the horizontal width inside each pulse (R9)
   task automatic frame(input int hl, input int lpr, input int rows,
                        input bit split_on, input bit mid_lower);
      for (int r = 0; r < rows; r++)
         for (int l = 0; l < lpr; l++)
            for (int h = 0; h < hl; h++) begin
               @(negedge clk);
               compare();
               hcc = 8'(h); vlc = 5'(l); vcc = 7'(r);
               split_border = split_on && (h == 3 || h == 4);
               if (mid_lower) begin
                  if (h == 0) r_sync_width[3:0] = 4'd6;
                  if (h == 5) r_sync_width[3:0] = 4'd2;
               end
            end
   endtask

   initial begin
      repeat (3) begin
         @(negedge clk);
         tag = "R10";
         n_checks++;
         if (hsync !== 0 || vsync !== 0 || disp_en !== 0) begin
            n_fail++;
            $display("FAIL R10 reset outputs actual=%b%b%b expected=000",
                     hsync, vsync, disp_en);
         end
      end
      rst_n = 1'b1;
      tag = "R1 R2 R4 R7"; frame(16, 4, 10, 0, 0); frame(16, 4, 10, 0, 0);
      tag = "R8 skew1"; r_skew = 2'b01; frame(16, 4, 10, 0, 0);
      tag = "R8 skew2"; r_skew = 2'b10; frame(16, 4, 10, 0, 0);
      tag = "R8 skew3"; r_skew = 2'b11; frame(16, 4, 10, 0, 0);
      r_skew = 2'b00;
      tag = "R3 split"; frame(16, 4, 10, 1, 0);
      tag = "R5 R7 zero widths"; r_sync_width = 8'h00; frame(16, 4, 10, 0, 0);
      frame(16, 4, 10, 0, 0);
      tag = "R1 R2 conflict"; r_hdisp = 0; r_vdisp = 0; r_sync_width = 8'h23;
      frame(16, 4, 10, 0, 0);
      r_hdisp = 10; r_vdisp = 6;
      tag = "R5 stop beats start"; r_hsync_pos = 0; r_sync_width = 8'h2F;
      frame(15, 4, 10, 0, 0); frame(15, 4, 10, 0, 0);
      tag = "R6 retrigger ignored"; r_vsync_pos = 0; r_sync_width = 8'h03;
      r_hsync_pos = 12; frame(16, 4, 3, 0, 0); frame(16, 4, 3, 0, 0);
      frame(16, 4, 3, 0, 0);
      tag = "R9 width lowered"; r_vsync_pos = 8; r_hsync_pos = 2;
      r_sync_width = 8'h26; frame(40, 2, 10, 0, 1);
      @(negedge clk); compare();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule